// File: doc/BRIEF.md
# Auto-Stepping Memory Pointer Unit

This block gives a 16-bit signal processor five indirect memory pointers. Each pointer has two independent slots, one used by reads and one by writes. Each slot holds a 16-bit word address and a 16-bit mode word. Software programs a slot in three steps. It writes the address half and then the mode half into a shared staging register. It then makes one blind access (an access whose data is discarded) to the pointer register. A blind read loads the staged value into the read slot, and a blind write loads it into the write slot.

After that, every ordinary read or write of the pointer register becomes one access to external DRAM, internal RAM or ROM. The unit then steps the slot's address as its mode word dictates. Writes to DRAM may use nibble-overwrite mode. In that mode only the nonzero 4-bit nibbles of the data reach the memory, through per-nibble write enables. The memories sit outside the block behind a simple port with combinational read data.

The staging register is run by a three-state sequencer:

| State | Meaning |
|---|---|
| `PH_ADDR` | Expecting the address half. |
| `PH_MODE` | Expecting the mode half. |
| `PH_ARMED` | Both halves held; waiting for a blind access. |

Its transitions are:

| Transition | From | To | Trigger |
|---|---|---|---|
| T1 | `PH_ADDR` | `PH_MODE` | Any access to the staging register. |
| T2 | `PH_MODE` | `PH_ARMED` | Any access to the staging register. |
| T3 | `PH_MODE` | `PH_ADDR` | Any pointer access (abandon). |
| T4 | `PH_ARMED` | `PH_ADDR` | Any pointer access (program or cancel). |
| T5 | `PH_ARMED` | `PH_MODE` | Any access to the staging register (restart). |

Top module: `memptr_unit`

## Requirements
- R1: Register select 7 addresses the staging register. Any read or write of it moves the sequencer along T1, T2 or T5. A write made in `PH_MODE` stores the mode half. A write made in any other state stores the address half.
- R2: A read of the staging register returns the stored address half on `reg_rdata` and advances the sequencer exactly as a write would.
- R3: In `PH_ARMED`, a blind pointer access programs a slot. A blind read loads the selected pointer's read slot and a blind write loads its write slot. The access makes no memory access and reads return zero. The sequencer returns to `PH_ADDR`.
- R4: In `PH_ARMED`, a pointer access with `reg_blind` low cancels the arming. It makes no memory access, returns zero and leaves every slot unchanged.
- R5: A pointer access in `PH_MODE` abandons the staged programming and returns the sequencer to `PH_ADDR`. It still performs its normal memory access.
- R6: A mode word whose bits 14 and 9..0 equal 0x018 selects DRAM (`mem_region` 0, `mem_addr` = the address zero-extended). Bits 13..11 set the stride: codes 0..7 give 0, 1, 2, 4, 8, 16, 32 and 128 words. Bit 15 makes the stride a decrement.
- R7: For a DRAM write whose mode bit 10 is set, `mem_nib_we[i]` is 1 only when data bits 4i+3..4i are nonzero. For every other accepted write all nibble enables are 1.
- R8: A mode word equal to 0x4018, ignoring bit 10, selects DRAM with cell stepping. An odd address advances by 31 and an even address advances by 1.
- R9: A mode word of the form 0x080b selects a ROM read in bank b (`mem_region` 2, `mem_addr` = {b, address}) with a stride of +1. A write through a ROM-mode slot is ignored.
- R10: A mode word whose bits 14, 10 and 9..0 equal 0x01C selects internal RAM (`mem_region` 1). Only the low 10 address bits drive `mem_addr`. The full 16-bit pointer keeps stepping across the 1024-word boundary without wrapping.
- R11: A slot with any other mode word returns zero on a read and makes no memory access on a read or a write. Its address does not change.
- R12: Each of the five pointers has separate read and write slots. Programming or stepping one slot leaves every other slot unchanged.
- R13: After reset the sequencer is in `PH_ADDR`, the staging register is zero and every slot holds mode 0, which is unsupported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. |
| rst_n | input | 1 | Active-low synchronous reset. |
| reg_valid | input | 1 | A register access is made this cycle. |
| reg_write | input | 1 | 1 = write, 0 = read. |
| reg_blind | input | 1 | Access whose data is discarded (used to program a slot). |
| reg_sel | input | 3 | 0..4 selects a pointer; 7 selects the staging register. |
| reg_wdata | input | 16 | Write data. |
| reg_rdata | output | 16 | Read data (combinational). |
| mem_en | output | 1 | Memory access strobe. |
| mem_we | output | 1 | Memory write. |
| mem_nib_we | output | 4 | Per-nibble write enables. |
| mem_region | output | 2 | 0 DRAM, 1 internal RAM, 2 ROM. |
| mem_addr | output | 20 | Word address (bank in the top 4 bits for ROM). |
| mem_wdata | output | 16 | Memory write data. |
| mem_rdata | input | 16 | Memory read data (combinational). |

## Verification
The bench steps through every stride code in both directions and the cell rule at odd and even addresses. A wrong stride table or an ignored decrement bit would show up as a wrong second address. The programming handshake is broken on purpose, by an early pointer access and by a non-blind access while armed. A design that let either one through would program a slot or issue a stray memory strobe. Overwrite writes are sent with sparse nibbles, and internal-RAM stepping is driven across its 1024-word boundary. A ROM-mode write and an unknown mode check that nothing reaches memory when the mode is unsupported.

// File: rtl/memptr_pkg.sv
package memptr_pkg;
    localparam int WORD_W     = 16;
    localparam int ROM_BANK_W = 4;
    localparam int NIB_N      = WORD_W / 4;

    typedef enum logic [1:0] {
        PH_ADDR  = 2'd0,
        PH_MODE  = 2'd1,
        PH_ARMED = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        RG_DRAM = 2'd0,
        RG_IRAM = 2'd1,
        RG_ROM  = 2'd2,
        RG_NONE = 2'd3
    } region_e;

    typedef struct packed {
        logic [WORD_W-1:0] addr;
        logic [WORD_W-1:0] mode;
    } slot_t;

    // stride code -> word count: 0,1,2,4,8,16,32,128
    function automatic logic [WORD_W-1:0] stride_of(input logic [2:0] code);
        logic [WORD_W-1:0] s;
        case (code)
            3'd0:    s = '0;
            3'd7:    s = WORD_W'(128);
            default: s = WORD_W'(1) << (code - 3'd1);
        endcase
        return s;
    endfunction
endpackage

// File: rtl/memptr_ctrl.sv
module memptr_ctrl
    import memptr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_acc,
    input  logic              ptr_acc,
    input  logic              acc_write,
    input  logic              acc_blind,
    input  logic [WORD_W-1:0] wdata,
    output phase_e            phase,
    output slot_t             ctl_word,
    output logic              ptr_hold,
    output logic              prog_rd,
    output logic              prog_wr
);
    phase_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PH_ADDR;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_word <= '0;
        end else if (ctl_acc && acc_write) begin
            if (state_q == PH_MODE) ctl_word.mode <= wdata;
            else                    ctl_word.addr <= wdata;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_ADDR:  if (ctl_acc) state_d = PH_MODE;                 // T1
            PH_MODE:  if (ctl_acc)      state_d = PH_ARMED;           // T2
                      else if (ptr_acc) state_d = PH_ADDR;            // T3
            PH_ARMED: if (ctl_acc)      state_d = PH_MODE;            // T5
                      else if (ptr_acc) state_d = PH_ADDR;            // T4
            default:  state_d = PH_ADDR;
        endcase
    end

    always_comb begin
        ptr_hold = ptr_acc && (state_q == PH_ARMED);
        prog_rd  = ptr_hold && acc_blind && !acc_write;
        prog_wr  = ptr_hold && acc_blind &&  acc_write;
    end

    assign phase = state_q;
endmodule

// File: rtl/memptr_slots.sv
module memptr_slots
    import memptr_pkg::*;
#(
    parameter int NPTR  = 5,
    parameter int SEL_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  sel,
    input  logic              acc_write,
    input  logic              prog_rd,
    input  logic              prog_wr,
    input  slot_t             prog_val,
    input  logic              step_en,
    input  logic [WORD_W-1:0] step_addr,
    output slot_t             cur
);
    slot_t rd_q [NPTR];
    slot_t wr_q [NPTR];

    always_ff @(posedge clk) begin
        for (int i = 0; i < NPTR; i++) begin
            if (!rst_n) begin
                rd_q[i] <= '0;
                wr_q[i] <= '0;
            end else if (sel == SEL_W'(i)) begin
                if (prog_rd) rd_q[i] <= prog_val;
                if (prog_wr) wr_q[i] <= prog_val;
                if (step_en && !acc_write) rd_q[i].addr <= step_addr;
                if (step_en &&  acc_write) wr_q[i].addr <= step_addr;
            end
        end
    end

    always_comb begin
        cur = '0;
        for (int i = 0; i < NPTR; i++)
            if (sel == SEL_W'(i)) cur = acc_write ? wr_q[i] : rd_q[i];
    end
endmodule

// File: rtl/memptr_step.sv
module memptr_step
    import memptr_pkg::*;
#(
    parameter int IRAM_AW = 10,
    localparam int MA_W   = WORD_W + ROM_BANK_W
) (
    input  slot_t             slot,
    input  logic              acc_write,
    input  logic [WORD_W-1:0] wdata,
    output logic              ok,
    output region_e           region,
    output logic [MA_W-1:0]   maddr,
    output logic [WORD_W-1:0] next_addr,
    output logic [NIB_N-1:0]  nib_we
);
    logic [WORD_W-1:0] m, a, delta;
    logic is_rom, is_cell, is_dram, is_iram;

    always_comb begin
        m       = slot.mode;
        a       = slot.addr;
        is_rom  = (m & 16'hFFF0) == 16'h0800;
        is_cell = (m & 16'hFBFF) == 16'h4018;
        is_dram = (m & 16'h43FF) == 16'h0018;
        is_iram = (m & 16'h47FF) == 16'h001C;
        delta   = stride_of(m[13:11]);
        ok        = 1'b0;
        region    = RG_NONE;
        maddr     = MA_W'(a);
        next_addr = a;
        nib_we    = '1;
        if (is_rom && !acc_write) begin
            ok        = 1'b1;
            region    = RG_ROM;
            maddr     = {m[ROM_BANK_W-1:0], a};
            next_addr = a + WORD_W'(1);
        end else if (is_cell) begin
            ok        = 1'b1;
            region    = RG_DRAM;
            next_addr = a + (a[0] ? WORD_W'(31) : WORD_W'(1));
        end else if (is_dram) begin
            ok        = 1'b1;
            region    = RG_DRAM;
            next_addr = m[15] ? a - delta : a + delta;
        end else if (is_iram) begin
            ok        = 1'b1;
            region    = RG_IRAM;
            maddr     = MA_W'(a[IRAM_AW-1:0]);
            next_addr = m[15] ? a - delta : a + delta;
        end
        if ((is_cell || is_dram) && m[10] && acc_write)
            for (int n = 0; n < NIB_N; n++) nib_we[n] = |wdata[4*n +: 4];
    end
endmodule

// File: rtl/memptr_unit.sv
module memptr_unit
    import memptr_pkg::*;
#(
    parameter int NPTR    = 5,
    parameter int SEL_W   = 3,
    parameter int CTL_SEL = 7,
    parameter int IRAM_AW = 10,
    localparam int MA_W   = WORD_W + ROM_BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_valid,
    input  logic              reg_write,
    input  logic              reg_blind,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              mem_en,
    output logic              mem_we,
    output logic [NIB_N-1:0]  mem_nib_we,
    output logic [1:0]        mem_region,
    output logic [MA_W-1:0]   mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata
);
    logic ctl_acc, ptr_acc, ptr_hold, prog_rd, prog_wr, ok, go;
    phase_e phase;
    slot_t ctl_word, cur;
    region_e region;
    logic [WORD_W-1:0] next_addr;
    logic [NIB_N-1:0] nib_we;
    logic [MA_W-1:0] maddr;

    assign ctl_acc = reg_valid && (reg_sel == SEL_W'(CTL_SEL));
    assign ptr_acc = reg_valid && (reg_sel < SEL_W'(NPTR));

    memptr_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .ctl_acc(ctl_acc), .ptr_acc(ptr_acc),
        .acc_write(reg_write), .acc_blind(reg_blind), .wdata(reg_wdata),
        .phase(phase), .ctl_word(ctl_word), .ptr_hold(ptr_hold),
        .prog_rd(prog_rd), .prog_wr(prog_wr)
    );

    memptr_slots #(.NPTR(NPTR), .SEL_W(SEL_W)) u_slots (
        .clk(clk), .rst_n(rst_n), .sel(reg_sel), .acc_write(reg_write),
        .prog_rd(prog_rd), .prog_wr(prog_wr), .prog_val(ctl_word),
        .step_en(go), .step_addr(next_addr), .cur(cur)
    );

    memptr_step #(.IRAM_AW(IRAM_AW)) u_step (
        .slot(cur), .acc_write(reg_write), .wdata(reg_wdata), .ok(ok),
        .region(region), .maddr(maddr), .next_addr(next_addr), .nib_we(nib_we)
    );

    assign go = ptr_acc && !ptr_hold && ok;

    always_comb begin
        mem_en     = go;
        mem_we     = go && reg_write;
        mem_nib_we = (go && reg_write) ? nib_we : '0;
        mem_region = region;
        mem_addr   = maddr;
        mem_wdata  = reg_wdata;
        if (ctl_acc && !reg_write)      reg_rdata = ctl_word.addr;
        else if (go && !reg_write)      reg_rdata = mem_rdata;
        else                            reg_rdata = '0;
    end
endmodule

// File: rtl/memptr_unit_chk.sv
module memptr_unit_chk #(
    parameter int NPTR    = 5,
    parameter int SEL_W   = 3,
    parameter int CTL_SEL = 7,
    parameter int IRAM_AW = 10,
    parameter int MA_W    = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_valid,
    input logic             reg_write,
    input logic [SEL_W-1:0] reg_sel,
    input logic [15:0]      reg_wdata,
    input logic [15:0]      reg_rdata,
    input logic             mem_en,
    input logic             mem_we,
    input logic [3:0]       mem_nib_we,
    input logic [1:0]       mem_region,
    input logic [MA_W-1:0]  mem_addr,
    input logic [1:0]       phase
);
    logic c_acc, p_acc;
    assign c_acc = reg_valid && (reg_sel == SEL_W'(CTL_SEL));
    assign p_acc = reg_valid && (reg_sel < SEL_W'(NPTR));

    p_ctl_advance_r1: assert property (@(posedge clk) disable iff (!rst_n)
        c_acc && phase == 2'd0 |=> phase == 2'd1);
    p_ctl_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        c_acc && !reg_write && phase == 2'd1 |=> phase == 2'd2);
    p_armed_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        p_acc && phase == 2'd2 |-> !mem_en && reg_rdata == 16'd0);
    p_armed_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        p_acc && phase == 2'd2 |=> phase == 2'd0);
    p_abandon_r5: assert property (@(posedge clk) disable iff (!rst_n)
        p_acc && phase == 2'd1 |=> phase == 2'd0);
    p_nib_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we && reg_wdata != 16'd0 |-> mem_nib_we != 4'd0);
    p_rom_read_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en && mem_region == 2'd2 |-> !mem_we);
    p_iram_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en && mem_region == 2'd1 |-> mem_addr[MA_W-1:IRAM_AW] == '0);
    p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        reg_valid && !reg_write && !c_acc && !mem_en |-> reg_rdata == 16'd0);
    p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_valid |-> !mem_en && !mem_we);
endmodule

bind memptr_unit memptr_unit_chk #(
    .NPTR(NPTR), .SEL_W(SEL_W), .CTL_SEL(CTL_SEL), .IRAM_AW(IRAM_AW), .MA_W(MA_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_en(mem_en), .mem_we(mem_we), .mem_nib_we(mem_nib_we),
    .mem_region(mem_region), .mem_addr(mem_addr), .phase(phase)
);

// File: tb/memptr_unit_tb.sv
`timescale 1ns/100ps
module memptr_unit_tb;
    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_valid = 0, reg_write = 0, reg_blind = 0;
    logic [2:0] reg_sel = 0;
    logic [15:0] reg_wdata = 0, reg_rdata, mem_wdata, mem_rdata;
    logic mem_en, mem_we;
    logic [3:0] mem_nib_we;
    logic [1:0] mem_region;
    logic [19:0] mem_addr;

    int total = 0, bad = 0;
    bit done = 0;
    logic [15:0] c_rdata, c_wdata;
    logic c_en, c_we;
    logic [3:0] c_nib;
    logic [1:0] c_region;
    logic [19:0] c_addr;

    always #2.5 clk = ~clk;

    assign mem_rdata = mem_addr[15:0] ^ 16'hA5A5;

    memptr_unit u_dut (
        .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
        .reg_blind(reg_blind), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .mem_en(mem_en), .mem_we(mem_we),
        .mem_nib_we(mem_nib_we), .mem_region(mem_region), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic acc(input logic [2:0] sel, input logic w, input logic b, input logic [15:0] d);
        @(negedge clk);
        reg_valid = 1; reg_sel = sel; reg_write = w; reg_blind = b; reg_wdata = d;
        #1;
        c_rdata = reg_rdata; c_en = mem_en; c_we = mem_we; c_nib = mem_nib_we;
        c_region = mem_region; c_addr = mem_addr; c_wdata = mem_wdata;
        @(posedge clk);
        #1 reg_valid = 0; reg_write = 0; reg_blind = 0;
    endtask

    task automatic prog(input logic [2:0] p, input logic w, input logic [15:0] a, input logic [15:0] m);
        acc(3'd7, 1, 0, a);
        acc(3'd7, 1, 0, m);
        acc(p, w, 1, 16'h0);
        chk("R3 blind program no mem access", {31'd0, c_en}, 32'd0);
    endtask

    task automatic rd_exp(input string tag, input logic [2:0] p, input logic [1:0] rg, input logic [19:0] ma);
        acc(p, 0, 0, 16'h0);
        chk({tag, " en"}, {31'd0, c_en}, 32'd1);
        chk({tag, " region"}, {30'd0, c_region}, {30'd0, rg});
        chk({tag, " addr"}, {12'd0, c_addr}, {12'd0, ma});
        chk({tag, " rdata"}, {16'd0, c_rdata}, {16'd0, ma[15:0] ^ 16'hA5A5});
    endtask

    task automatic wr_exp(input string tag, input logic [2:0] p, input logic [15:0] d,
                          input logic [1:0] rg, input logic [19:0] ma, input logic [3:0] nib);
        acc(p, 1, 0, d);
        chk({tag, " we"}, {30'd0, c_en, c_we}, 32'd3);
        chk({tag, " region"}, {30'd0, c_region}, {30'd0, rg});
        chk({tag, " addr"}, {12'd0, c_addr}, {12'd0, ma});
        chk({tag, " nib"}, {28'd0, c_nib}, {28'd0, nib});
        chk({tag, " wdata"}, {16'd0, c_wdata}, {16'd0, d});
    endtask

    task automatic t_reset();
        acc(3'd7, 0, 0, 16'h0);
        chk("R13 staging reads zero", {16'd0, c_rdata}, 32'd0);
        acc(3'd0, 0, 0, 16'h0);
        chk("R13 reset slot read no access", {31'd0, c_en}, 32'd0);
        chk("R13 reset slot read zero", {16'd0, c_rdata}, 32'd0);
        acc(3'd0, 1, 0, 16'h1234);
        chk("R13 reset slot write ignored", {31'd0, c_we}, 32'd0);
    endtask

    task automatic t_dram();
        prog(3'd1, 0, 16'h0100, 16'h0818);
        rd_exp("R6 inc1 a", 3'd1, 2'd0, 20'h00100);
        rd_exp("R6 inc1 b", 3'd1, 2'd0, 20'h00101);
        prog(3'd1, 0, 16'h0200, 16'h3018);
        rd_exp("R6 inc32 a", 3'd1, 2'd0, 20'h00200);
        rd_exp("R6 inc32 b", 3'd1, 2'd0, 20'h00220);
        prog(3'd1, 0, 16'h0300, 16'hA818);
        rd_exp("R6 dec16 a", 3'd1, 2'd0, 20'h00300);
        rd_exp("R6 dec16 b", 3'd1, 2'd0, 20'h002F0);
        prog(3'd1, 0, 16'h0400, 16'hB818);
        rd_exp("R6 dec128 a", 3'd1, 2'd0, 20'h00400);
        rd_exp("R6 dec128 b", 3'd1, 2'd0, 20'h00380);
        prog(3'd1, 0, 16'h0600, 16'h2018);
        rd_exp("R6 inc8 a", 3'd1, 2'd0, 20'h00600);
        rd_exp("R6 inc8 b", 3'd1, 2'd0, 20'h00608);
        prog(3'd1, 0, 16'h0500, 16'h0018);
        rd_exp("R6 stride0 a", 3'd1, 2'd0, 20'h00500);
        rd_exp("R6 stride0 b", 3'd1, 2'd0, 20'h00500);
    endtask

    task automatic t_slots();
        prog(3'd1, 1, 16'h0700, 16'h1018);
        wr_exp("R12 write slot a", 3'd1, 16'h0030, 2'd0, 20'h00700, 4'hF);
        wr_exp("R12 write slot b", 3'd1, 16'h0031, 2'd0, 20'h00702, 4'hF);
        rd_exp("R12 read slot kept", 3'd1, 2'd0, 20'h00500);
        acc(3'd2, 0, 0, 16'h0);
        chk("R12 other pointer untouched", {31'd0, c_en}, 32'd0);
    endtask

    task automatic t_overwrite();
        prog(3'd2, 1, 16'h0040, 16'h0C18);
        wr_exp("R7 overwrite one nibble", 3'd2, 16'h0F00, 2'd0, 20'h00040, 4'b0100);
        wr_exp("R7 overwrite two nibbles", 3'd2, 16'hA0B0, 2'd0, 20'h00041, 4'b1010);
    endtask

    task automatic t_cell();
        prog(3'd3, 1, 16'h0010, 16'h4018);
        wr_exp("R8 cell even", 3'd3, 16'h1111, 2'd0, 20'h00010, 4'hF);
        wr_exp("R8 cell +1", 3'd3, 16'h2222, 2'd0, 20'h00011, 4'hF);
        wr_exp("R8 cell +31", 3'd3, 16'h3333, 2'd0, 20'h00030, 4'hF);
        wr_exp("R8 cell +1 again", 3'd3, 16'h4444, 2'd0, 20'h00031, 4'hF);
        wr_exp("R8 cell +31 again", 3'd3, 16'h5555, 2'd0, 20'h00050, 4'hF);
        prog(3'd3, 0, 16'h0021, 16'h4018);
        rd_exp("R8 cell read odd", 3'd3, 2'd0, 20'h00021);
        rd_exp("R8 cell read after odd", 3'd3, 2'd0, 20'h00040);
    endtask

    task automatic t_rom();
        prog(3'd4, 0, 16'h1230, 16'h0805);
        rd_exp("R9 rom bank5 a", 3'd4, 2'd2, 20'h51230);
        rd_exp("R9 rom bank5 b", 3'd4, 2'd2, 20'h51231);
        prog(3'd4, 1, 16'h1230, 16'h0805);
        acc(3'd4, 1, 0, 16'hBEEF);
        chk("R9 rom write ignored", {30'd0, c_en, c_we}, 32'd0);
    endtask

    task automatic t_iram();
        prog(3'd0, 1, 16'h83FF, 16'h081C);
        wr_exp("R10 iram top", 3'd0, 16'h0101, 2'd1, 20'h003FF, 4'hF);
        wr_exp("R10 iram cross", 3'd0, 16'h0202, 2'd1, 20'h00000, 4'hF);
        wr_exp("R10 iram next", 3'd0, 16'h0303, 2'd1, 20'h00001, 4'hF);
        prog(3'd0, 0, 16'h0005, 16'h101C);
        rd_exp("R10 iram read a", 3'd0, 2'd1, 20'h00005);
        rd_exp("R10 iram read b", 3'd0, 2'd1, 20'h00007);
    endtask

    task automatic t_cancel();
        acc(3'd7, 1, 0, 16'h0A00);
        acc(3'd7, 1, 0, 16'h0818);
        acc(3'd0, 0, 0, 16'h0);
        chk("R4 cancel no access", {31'd0, c_en}, 32'd0);
        chk("R4 cancel reads zero", {16'd0, c_rdata}, 32'd0);
        rd_exp("R4 slot unchanged", 3'd0, 2'd1, 20'h00009);
    endtask

    task automatic t_abandon();
        acc(3'd7, 1, 0, 16'h0B00);
        rd_exp("R5 abandon still accesses", 3'd0, 2'd1, 20'h0000B);
        acc(3'd7, 0, 0, 16'h0);
        chk("R2 staging read returns addr", {16'd0, c_rdata}, 32'h0B00);
        acc(3'd7, 1, 0, 16'h0818);
        acc(3'd1, 0, 1, 16'h0);
        chk("R1 read advanced phase so blind programs", {31'd0, c_en}, 32'd0);
        rd_exp("R1 programmed addr", 3'd1, 2'd0, 20'h00B00);
        rd_exp("R1 programmed step", 3'd1, 2'd0, 20'h00B01);
    endtask

    task automatic t_unsup();
        prog(3'd2, 0, 16'h0123, 16'h0019);
        for (int k = 0; k < 2; k++) begin
            acc(3'd2, 0, 0, 16'h0);
            chk("R11 unsupported read no access", {31'd0, c_en}, 32'd0);
            chk("R11 unsupported read zero", {16'd0, c_rdata}, 32'd0);
        end
        prog(3'd2, 1, 16'h0123, 16'h0019);
        acc(3'd2, 1, 0, 16'hFFFF);
        chk("R11 unsupported write ignored", {30'd0, c_en, c_we}, 32'd0);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1;
        t_reset();
        t_dram();
        t_slots();
        t_overwrite();
        t_cell();
        t_rom();
        t_iram();
        t_cancel();
        t_abandon();
        t_unsup();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule